// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is an I2C bus master that software steers one step at a time. Each write to the command register starts exactly one bus step: a START (or repeated START), a byte transmission, a byte reception that ends with an ACK or a NACK, a STOP, or a chain of these that the command bits select together. When the step has finished, the block raises an "operation over" flag, which can drive the interrupt line. Software then reads the status and the received byte, clears the flags it has seen, and issues the next step. Addresses are 7-bit. Software places the address byte, including the direction bit, in the transmit register and sends it with a START+WRITE command.

The bus pins are open-drain. The block only ever pulls SCL or SDA low, through its output-enable ports, and it samples the resolved SDA level. The SCL low time and the SCL high time each come from their own count register. The block reports a byte that the slave did not acknowledge, and it detects when another master wins arbitration. Clearing the enable bit aborts any step in progress and releases the bus at once.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the control (0x00), command (0x04) and status (0x0C) registers read 0, both SCL count registers (0x10 high, 0x14 low) read the default count, irq is low, and neither bus line is pulled low.
- R2: With count N in the SCL high register (0x10) the SCL high phase lasts 2*(N+1) clocks, and with count M in the low register (0x14) the low phase lasts 2*(M+1) clocks.
- R3: A command with start (bit 3) and write (bit 1) issues a START condition and then shifts out the transmit byte (0x18), MSB first. It then sets the start (status bit 6), send (bit 4) and operation-over (bit 0) flags, and SDA does not change while SCL is released within a bit.
- R4: When SDA is sampled high on the ninth clock of a transmitted byte, the ack-error flag (status bit 2) is set.
- R5: A read command (bit 2) clocks in a byte MSB first, stores it in the receive register (0x1C) and sets the receive flag (status bit 3). On the ninth clock the master pulls SDA low, unless the no-ack bit (bit 4) is set, in which case it leaves SDA released.
- R6: Status bit 7 (busy) is set once a START completes. A stop command (bit 0) produces a STOP condition, sets the end flag (status bit 5) and clears busy.
- R7: When the master sends a 1 on a data bit but samples SDA low, it sets the arbitration flag (status bit 1) and the operation-over flag, releases both lines and clears busy.
- R8: A write to the interrupt-clear register (0x08) clears exactly the status flags whose bit positions (6..0) are written as 1 and leaves the others unchanged.
- R9: irq is high exactly when control bit 8 (enable) and bit 7 (global unmask) are both set and some pending flag has its unmask bit (control bits 6..0, same positions as the status flags) set.
- R10: While a command is executing, the command register reads back that command. Further command writes are ignored. The command register clears when operation-over is set.
- R11: Clearing control bit 8 aborts the step in progress, releases SDA and SCL without a STOP, sets no operation-over flag and clears busy. Command writes are ignored while the core is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt request |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Assertions check four things on every cycle. The enable bit releasing both lines within one clock. SDA staying steady while SCL is released inside a bit. A command starting only from the idle engine and the command register clearing after operation-over. Write-one-to-clear on each flag. The bench scenarios, run against a behavioural slave on the wired-AND bus, are what show the rest: that the bytes sent and received carry the right values, that ACK and NACK come on the ninth clock, that the flag patterns after each kind of step are correct, that SCL phase lengths follow the count registers, and that an abort does not produce a spurious STOP.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_ICR  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_SCLH = 8'h10;
  localparam logic [7:0] OFS_SCLL = 8'h14;
  localparam logic [7:0] OFS_TX   = 8'h18;
  localparam logic [7:0] OFS_RX   = 8'h1C;

  // control bits
  localparam int CB_EN  = 8;
  localparam int CB_GIE = 7;

  // command bits
  localparam int CM_STOP  = 0;
  localparam int CM_WRITE = 1;
  localparam int CM_READ  = 2;
  localparam int CM_START = 3;
  localparam int CM_NACK  = 4;
  localparam int NCMD     = 5;

  // flag positions (status, clear and unmask share them)
  localparam int FL_OVER  = 0;
  localparam int FL_ARB   = 1;
  localparam int FL_ACK   = 2;
  localparam int FL_RECV  = 3;
  localparam int FL_SEND  = 4;
  localparam int FL_END   = 5;
  localparam int FL_START = 6;
  localparam int NFLAG    = 7;

  typedef enum logic [3:0] {
    E_IDLE, E_RS_PRE, E_ST_A, E_ST_B, E_BIT_LO, E_BIT_HI,
    E_SP_LO, E_SP_HI, E_SP_END
  } eng_state_t;
endpackage

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             go,
  input  logic [NCMD-1:0]  cmd,
  input  logic [7:0]       tx_byte,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic [NFLAG-1:0] flag_set,
  output logic [7:0]       rx_byte,
  output logic             rx_load
);
  localparam int PW = CNT_W + 1;

  eng_state_t      state_q, state_d;
  logic [PW-1:0]   cnt_q, cnt_d, term;
  logic [3:0]      bit_q, bit_d;
  logic [NCMD-1:0] cmd_q, cmd_d;
  logic [7:0]      sh_q, sh_d;
  logic            hold_q, hold_d;
  logic            busy_q, busy_d;
  logic            sda_last_q;
  logic            ph_end, lo_phase, xfer, finish, bit_drv;

  assign lo_phase = (state_q == E_RS_PRE) || (state_q == E_BIT_LO) || (state_q == E_SP_LO);
  assign term     = lo_phase ? {lo_cnt, 1'b1} : {hi_cnt, 1'b1};
  assign ph_end   = (cnt_q >= term);
  assign xfer     = cmd_q[CM_WRITE] | cmd_q[CM_READ];

  // level the master puts on SDA during the current bit
  always_comb begin
    if (cmd_q[CM_WRITE]) bit_drv = (bit_q < 4'd8) ? ~sh_q[7] : 1'b0;
    else                 bit_drv = (bit_q < 4'd8) ? 1'b0 : ~cmd_q[CM_NACK];
  end

  // next state
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q + 1'b1;
    bit_d    = bit_q;
    cmd_d    = cmd_q;
    sh_d     = sh_q;
    hold_d   = hold_q;
    busy_d   = busy_q;
    flag_set = '0;
    rx_load  = 1'b0;
    finish   = 1'b0;
    if (state_q == E_IDLE || ph_end) cnt_d = '0;
    if (!en) begin
      state_d = E_IDLE;
      cnt_d   = '0;
      hold_d  = 1'b0;
      busy_d  = 1'b0;
    end else begin
      case (state_q)
        E_IDLE: if (go) begin
          cmd_d = cmd;
          sh_d  = tx_byte;
          bit_d = '0;
          if (cmd[CM_START])                      state_d = hold_q ? E_RS_PRE : E_ST_A;
          else if (cmd[CM_WRITE] || cmd[CM_READ]) state_d = E_BIT_LO;
          else                                    state_d = E_SP_LO;
        end
        E_RS_PRE: if (ph_end) state_d = E_ST_A;
        E_ST_A:   if (ph_end) state_d = E_ST_B;
        E_ST_B: if (ph_end) begin
          busy_d             = 1'b1;
          hold_d             = 1'b1;
          flag_set[FL_START] = 1'b1;
          if (xfer)                 state_d = E_BIT_LO;
          else if (cmd_q[CM_STOP])  state_d = E_SP_LO;
          else                      finish  = 1'b1;
        end
        E_BIT_LO: if (ph_end) state_d = E_BIT_HI;
        E_BIT_HI: if (ph_end) begin
          if (bit_q < 4'd8) begin
            if (cmd_q[CM_WRITE] && sh_q[7] && !sda_i) begin
              state_d          = E_IDLE;
              hold_d           = 1'b0;
              busy_d           = 1'b0;
              flag_set[FL_ARB] = 1'b1;
              flag_set[FL_OVER]= 1'b1;
            end else begin
              sh_d    = {sh_q[6:0], sda_i};
              bit_d   = bit_q + 1'b1;
              state_d = E_BIT_LO;
            end
          end else begin
            hold_d = 1'b1;
            if (cmd_q[CM_WRITE]) begin
              flag_set[FL_SEND] = 1'b1;
              flag_set[FL_ACK]  = sda_i;
            end else begin
              flag_set[FL_RECV] = 1'b1;
              rx_load           = 1'b1;
            end
            if (cmd_q[CM_STOP]) state_d = E_SP_LO;
            else                finish  = 1'b1;
          end
        end
        E_SP_LO: if (ph_end) state_d = E_SP_HI;
        E_SP_HI: if (ph_end) state_d = E_SP_END;
        E_SP_END: if (ph_end) begin
          busy_d           = 1'b0;
          hold_d           = 1'b0;
          flag_set[FL_END] = 1'b1;
          finish           = 1'b1;
        end
        default: state_d = E_IDLE;
      endcase
      if (finish) begin
        state_d           = E_IDLE;
        flag_set[FL_OVER] = 1'b1;
      end
    end
  end

  // line drive
  always_comb begin
    case (state_q)
      E_RS_PRE: begin scl_oe = 1'b1; sda_oe = 1'b0;    end
      E_ST_A:   begin scl_oe = 1'b0; sda_oe = 1'b0;    end
      E_ST_B:   begin scl_oe = 1'b0; sda_oe = 1'b1;    end
      E_BIT_LO: begin scl_oe = 1'b1; sda_oe = bit_drv; end
      E_BIT_HI: begin scl_oe = 1'b0; sda_oe = bit_drv; end
      E_SP_LO:  begin scl_oe = 1'b1; sda_oe = 1'b1;    end
      E_SP_HI:  begin scl_oe = 1'b0; sda_oe = 1'b1;    end
      E_SP_END: begin scl_oe = 1'b0; sda_oe = 1'b0;    end
      default:  begin scl_oe = hold_q; sda_oe = hold_q & sda_last_q; end
    endcase
  end

  assign busy    = busy_q;
  assign rx_byte = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= E_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      cmd_q      <= '0;
      sh_q       <= '0;
      hold_q     <= 1'b0;
      busy_q     <= 1'b0;
      sda_last_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      bit_q      <= bit_d;
      cmd_q      <= cmd_d;
      sh_q       <= sh_d;
      hold_q     <= hold_d;
      busy_q     <= busy_d;
      sda_last_q <= sda_oe;
    end
  end

  // R11: a cleared enable leaves both lines released on the next cycle
  p_abort_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R3: SDA holds while SCL is released inside a bit
  p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == E_BIT_HI && $past(state_q) == E_BIT_HI) |-> $stable(sda_oe));

  // R10: a new command is only handed over to an idle engine
  p_go_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (state_q == E_IDLE));
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int CNT_W   = 16,
  parameter int DEF_CNT = 124
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             core_en,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [7:0]       tx_byte,
  output logic             go,
  output logic [NCMD-1:0]  cmd,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [7:0]       rx_byte,
  input  logic             rx_load,
  input  logic             busy
);
  localparam int CW = CB_EN + 1;

  logic [CW-1:0]    ctrl_q, ctrl_d;
  logic [NCMD-1:0]  cmd_q, cmd_d;
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [7:0]       tx_q, tx_d, rx_q, rx_d;
  logic             wr, wr_ctrl, wr_cmd, wr_icr, wr_sclh, wr_scll, wr_tx;
  logic             unused_bits;

  assign unused_bits = ^{bus_sel, bus_wdata};

  assign wr      = bus_sel & bus_wr;
  assign wr_ctrl = wr && (bus_addr == OFS_CTRL[AW-1:0]);
  assign wr_cmd  = wr && (bus_addr == OFS_CMD[AW-1:0]);
  assign wr_icr  = wr && (bus_addr == OFS_ICR[AW-1:0]);
  assign wr_sclh = wr && (bus_addr == OFS_SCLH[AW-1:0]);
  assign wr_scll = wr && (bus_addr == OFS_SCLL[AW-1:0]);
  assign wr_tx   = wr && (bus_addr == OFS_TX[AW-1:0]);

  assign go = wr_cmd && ctrl_q[CB_EN] && (cmd_q == '0) && (|bus_wdata[CM_START:CM_STOP]);

  always_comb begin
    ctrl_d = wr_ctrl ? bus_wdata[CW-1:0]    : ctrl_q;
    hi_d   = wr_sclh ? bus_wdata[CNT_W-1:0] : hi_q;
    lo_d   = wr_scll ? bus_wdata[CNT_W-1:0] : lo_q;
    tx_d   = wr_tx   ? bus_wdata[7:0]       : tx_q;
    rx_d   = rx_load ? rx_byte              : rx_q;
    if (!ctrl_q[CB_EN] || flag_set[FL_OVER]) cmd_d = '0;
    else if (go)                             cmd_d = bus_wdata[NCMD-1:0];
    else                                     cmd_d = cmd_q;
  end

  // per-flag write-one-to-clear, with a new event taking precedence
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    assign flags_d[k] = flag_set[k] | (flags_q[k] & ~(wr_icr & bus_wdata[k]));

    // R8: a written 1 clears the flag when no new event arrives
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_icr && bus_wdata[k] && !flag_set[k]) |=> !flags_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      flags_q <= '0;
      hi_q    <= CNT_W'(DEF_CNT);
      lo_q    <= CNT_W'(DEF_CNT);
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmd_q   <= cmd_d;
      flags_q <= flags_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL[AW-1:0]: bus_rdata = 32'(ctrl_q);
      OFS_CMD[AW-1:0]:  bus_rdata = 32'(cmd_q);
      OFS_STAT[AW-1:0]: bus_rdata = 32'({busy, flags_q});
      OFS_SCLH[AW-1:0]: bus_rdata = 32'(hi_q);
      OFS_SCLL[AW-1:0]: bus_rdata = 32'(lo_q);
      OFS_TX[AW-1:0]:   bus_rdata = 32'(tx_q);
      OFS_RX[AW-1:0]:   bus_rdata = 32'(rx_q);
      default:          bus_rdata = '0;
    endcase
  end

  assign irq     = ctrl_q[CB_EN] & ctrl_q[CB_GIE] & (|(flags_q & ctrl_q[NFLAG-1:0]));
  assign core_en = ctrl_q[CB_EN];
  assign hi_cnt  = hi_q;
  assign lo_cnt  = lo_q;
  assign tx_byte = tx_q;
  assign cmd     = bus_wdata[NCMD-1:0];

  // R10: the command register empties once operation-over is raised
  p_cmd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[FL_OVER] |=> (cmd_q == '0));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int CNT_W   = 16,
  parameter int DEF_CNT = 124
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic [1:0]       rs_q;
  logic             rst_n_s;
  logic             core_en, go, rx_load, busy;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic [7:0]       tx_byte, rx_byte;
  logic [NCMD-1:0]  cmd;
  logic [NFLAG-1:0] flag_set;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  i2c_cmd_regs #(.AW(AW), .CNT_W(CNT_W), .DEF_CNT(DEF_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .core_en(core_en), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .tx_byte(tx_byte), .go(go), .cmd(cmd),
    .flag_set(flag_set), .rx_byte(rx_byte), .rx_load(rx_load), .busy(busy)
  );

  i2c_cmd_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n_s),
    .en(core_en), .go(go), .cmd(cmd), .tx_byte(tx_byte),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .flag_set(flag_set), .rx_byte(rx_byte), .rx_load(rx_load)
  );
endmodule

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq, scl_oe, sda_oe;
  logic          slv_drive, force_low;
  logic          scl_w, sda_w;

  int checks = 0, errors = 0, cycles = 0;
  bit done_f = 0;

  // bus slave model state
  int   pos = 0, dpos = 0, start_cnt = 0, stop_cnt = 0;
  int   run = 0, last_hi = 0, last_lo = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] rxsh = '0, slv_rx = '0, slv_tx = '0;
  logic ack_seen = 1'b1, slv_tx_mode = 1'b0, slv_ack_en = 1'b1;
  bit   quiet_chk = 0;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_drive | force_low);

  always #(CLK_P/2) clk = ~clk;

  i2c_cmd_master #(.AW(AW), .CNT_W(16), .DEF_CNT(124)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_comb begin
    if (slv_tx_mode) slv_drive = (dpos < 8) ? ~slv_tx[7 - (dpos % 8)] : 1'b0;
    else             slv_drive = (dpos == 8) && slv_ack_en;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural slave and line monitor, sampled between edges
  always @(negedge clk) begin
    cycles++;
    if (scl_w == prev_scl) run++;
    else begin
      if (prev_scl) last_hi = run; else last_lo = run;
      run = 1;
    end
    if (scl_w && prev_scl && prev_sda && !sda_w) begin
      start_cnt++; pos = 0;
    end else if (scl_w && prev_scl && !prev_sda && sda_w) stop_cnt++;
    if (!prev_scl && scl_w) begin
      if (pos < 8) rxsh = {rxsh[6:0], sda_w};
      if (pos == 7) slv_rx = rxsh;
      if (pos == 8) ack_seen = sda_w;
      pos = (pos == 8) ? 0 : pos + 1;
    end
    if (prev_scl && !scl_w) dpos = pos;
    prev_scl = scl_w;
    prev_sda = sda_w;
    if (quiet_chk) chk("R1/R11 lines released per cycle", {30'd0, scl_oe, sda_oe}, 32'd0);
  end

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[AW-1:0];
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (irq !== 1'b1 && n < 4000) begin @(negedge clk); n++; end
    chk({tag, " irq after step"}, {31'd0, irq}, 32'd1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (!done_f) begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] v;
    force_low = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet_chk = 1;
    // R1 reset state
    br(8'h00, v); chk("R1 control", v, 32'h0);
    br(8'h04, v); chk("R1 command", v, 32'h0);
    br(8'h0C, v); chk("R1 status", v, 32'h0);
    br(8'h10, v); chk("R1 scl high", v, 32'd124);
    br(8'h14, v); chk("R1 scl low", v, 32'd124);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    quiet_chk = 0;

    bw(8'h10, 1); bw(8'h14, 1);
    bw(8'h00, 32'h181);

    // R3 start + address byte
    bw(8'h18, 32'hA4);
    bw(8'h04, 32'h0A);
    br(8'h04, v); chk("R10 command readback while running", v, 32'h0A);
    bw(8'h04, 32'h01);
    wait_irq("R3");
    br(8'h0C, v); chk("R3 status start+send+over, R6 busy", v, 32'hD1);
    chk("R3 slave received byte", {24'd0, slv_rx}, 32'hA4);
    chk("R3 one start seen", start_cnt, 1);
    chk("R10 ignored stop did not reach bus", stop_cnt, 0);
    br(8'h04, v); chk("R10 command cleared", v, 32'h0);
    chk("R2 high phase N=1", last_hi, 4);
    chk("R2 low phase M=1", last_lo, 4);
    bw(8'h08, 32'hD1);
    br(8'h0C, v); chk("R8 write back status clears flags", v, 32'h80);
    chk("R9 irq low after clear", {31'd0, irq}, 32'd0);

    // R4 missing acknowledge
    slv_ack_en = 1'b0;
    bw(8'h18, 32'h3C);
    bw(8'h04, 32'h02);
    wait_irq("R4");
    slv_ack_en = 1'b1;
    br(8'h0C, v); chk("R4 ack error flag", v, 32'h95);
    chk("R4 data byte on bus", {24'd0, slv_rx}, 32'h3C);
    bw(8'h08, 32'h01);
    br(8'h0C, v); chk("R8 partial clear", v, 32'h94);
    chk("R9 irq masked flags", {31'd0, irq}, 32'd0);
    bw(8'h00, 32'h185);
    @(negedge clk);
    chk("R9 irq on ack unmask", {31'd0, irq}, 32'd1);
    bw(8'h00, 32'h105);
    @(negedge clk);
    chk("R9 irq off without global unmask", {31'd0, irq}, 32'd0);
    bw(8'h00, 32'h181);
    bw(8'h08, 32'h14);
    br(8'h0C, v); chk("R8 clear remainder", v, 32'h80);

    // R5 repeated start, read with ack then nack
    bw(8'h18, 32'hA5);
    bw(8'h04, 32'h0A);
    wait_irq("R5");
    chk("R5 repeated start seen", start_cnt, 2);
    bw(8'h08, 32'h7F);
    slv_tx = 8'h5A; slv_tx_mode = 1'b1;
    bw(8'h04, 32'h04);
    wait_irq("R5");
    br(8'h0C, v); chk("R5 receive flag", v, 32'h89);
    br(8'h1C, v); chk("R5 received byte", v, 32'h5A);
    chk("R5 master ack low", {31'd0, ack_seen}, 32'd0);
    bw(8'h08, 32'h7F);
    slv_tx = 8'hC3;
    bw(8'h04, 32'h14);
    wait_irq("R5");
    br(8'h1C, v); chk("R5 last byte", v, 32'hC3);
    chk("R5 master nack high", {31'd0, ack_seen}, 32'd1);
    slv_tx_mode = 1'b0;
    bw(8'h08, 32'h7F);

    // R6 stop
    bw(8'h04, 32'h01);
    wait_irq("R6");
    br(8'h0C, v); chk("R6 end flag, busy clear", v, 32'h21);
    chk("R6 stop seen", stop_cnt, 1);
    bw(8'h08, 32'h7F);
    quiet_chk = 1; repeat (3) @(negedge clk); quiet_chk = 0;

    // R2 unequal phases
    bw(8'h10, 2);
    bw(8'h18, 32'hA4);
    bw(8'h04, 32'h0A);
    wait_irq("R2");
    chk("R2 high phase N=2", last_hi, 6);
    chk("R2 low phase M=1", last_lo, 4);
    bw(8'h08, 32'h7F);
    bw(8'h04, 32'h01);
    wait_irq("R2");
    bw(8'h08, 32'h7F);
    bw(8'h10, 1);

    // R7 arbitration loss
    bw(8'h18, 32'hA4);
    bw(8'h04, 32'h0A);
    wait_irq("R7");
    bw(8'h08, 32'h7F);
    force_low = 1'b1;
    bw(8'h18, 32'h80);
    bw(8'h04, 32'h02);
    wait_irq("R7");
    br(8'h0C, v); chk("R7 arbitration flags, busy clear", v, 32'h03);
    chk("R7 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    chk("R7 no stop emitted", stop_cnt, 2);
    force_low = 1'b0;
    bw(8'h08, 32'h7F);
    repeat (3) @(negedge clk);

    // R11 abort by disable
    v = stop_cnt;
    bw(8'h18, 32'hA4);
    bw(8'h04, 32'h0A);
    repeat (10) @(negedge clk);
    bw(8'h00, 32'h000);
    @(negedge clk);
    quiet_chk = 1;
    br(8'h0C, v); chk("R11 start flag only, no over, busy clear", v, 32'h40);
    bw(8'h04, 32'h0A);
    br(8'h04, v); chk("R11 command ignored while disabled", v, 32'h0);
    chk("R11 no stop on abort", stop_cnt, 3);
    quiet_chk = 0;
    bw(8'h00, 32'h181);
    bw(8'h08, 32'h7F);
    bw(8'h04, 32'h0A);
    wait_irq("R11");
    br(8'h0C, v); chk("R11 restart after abort", v, 32'hD1);
    bw(8'h08, 32'h7F);
    bw(8'h04, 32'h01);
    wait_irq("R11");
    br(8'h0C, v); chk("R6 final stop", v, 32'h21);

    done_f = 1;
    finish_run();
  end
endmodule